// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Retry Sequencer

This block runs the transmission of one frame out of a paged buffer memory in a half-duplex Ethernet MAC. Software loads a start page and a 16-bit byte count, then pulses a transmit request. The block clears its transmit status and latches the page and count. It waits until the receive path is quiet and the interframe gap has run out. It then walks a byte offset through the frame and issues one buffer read address per byte on a valid/ready stream.

On a collision reported by the serializer, the block flushes the transmit FIFO and rewinds the offset to the start of the frame. It counts the collision, waits for the external backoff timer to signal completion, waits for the gap again and resends from the first byte. If the fifteenth retry also collides, the block gives up. It then flags an abort and forces the collision count to zero. A frame completes when the serializer reports end of frame after every byte has been fetched. At that point a done status bit is set and a one-cycle done pulse is issued.

The read-address stream follows valid/ready rules. While `rd_valid` is high and `rd_ready` is low, `rd_addr` and `rd_valid` stay steady, unless a collision withdraws the request. A transfer happens on each clock edge where both are high. The consumer may hold `rd_ready` low for any number of cycles.

Top module: `tx_retry_ctrl`

## Requirements
- R1: After reset, `tx_busy`, `rd_valid`, `fifo_flush`, `tx_done`, `stat_ptx`, `stat_col` and `stat_abt` are low and `coll_count` is 0.
- R2: A `tx_req_set` pulse while idle raises `tx_busy` on the next edge. It clears `stat_ptx`, `stat_col`, `stat_abt` and `coll_count`, and latches `start_page` and `byte_count`. A `tx_req_set` pulse while `tx_busy` is high has no effect.
- R3: No read address is offered (`rd_valid` low) while `rx_busy` is high or `ifg_done` is low during the wait before an attempt.
- R4: Read addresses are `{start_page, 8'h00} + k` for k = 0 up to `byte_count`-1, in increasing order. Each k is offered until accepted, and `rd_addr` holds steady while stalled.
- R5: After the last byte is accepted, `rd_valid` stays low. An `end_of_frame` pulse then sets `stat_ptx`, drops `tx_busy` and gives a `tx_done` pulse exactly one cycle wide.
- R6: A `collision` pulse during an attempt produces a one-cycle `fifo_flush` pulse in the next cycle. It increments `coll_count`, sets `stat_col` and rewinds the offset to 0.
- R7: After a collision, no address is offered until `backoff_done` has pulsed and the gap condition of R3 holds again. The retry restarts at offset 0.
- R8: A collision when `coll_count` is 15 aborts the frame. `stat_abt` is set, `coll_count` reads 0, `tx_busy` drops, `fifo_flush` pulses and no `tx_done` is issued.
- R9: A `collision` pulse while idle, waiting for the gap, or waiting for backoff changes neither `coll_count` nor `fifo_flush`.
- R10: A collision after the last byte has been fetched but before `end_of_frame` is still honoured as in R6. When it arrives in the same cycle as `end_of_frame`, the collision wins and no `tx_done` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_page | input | 8 | Buffer page of the first frame byte |
| byte_count | input | 16 | Frame length in bytes |
| tx_req_set | input | 1 | Transmit request pulse |
| rx_busy | input | 1 | Receive path is taking a frame |
| ifg_done | input | 1 | Interframe gap has expired |
| backoff_done | input | 1 | Backoff delay finished strobe |
| collision | input | 1 | Collision detected strobe |
| end_of_frame | input | 1 | Serializer finished the frame |
| rd_valid | output | 1 | Read address valid |
| rd_ready | input | 1 | Consumer accepts read address |
| rd_addr | output | 16 | Buffer byte address |
| fifo_flush | output | 1 | Transmit FIFO reset pulse |
| tx_busy | output | 1 | Transmit request bit, high while a frame is in progress |
| tx_done | output | 1 | One-cycle frame complete pulse |
| stat_ptx | output | 1 | Frame sent without abort |
| stat_col | output | 1 | At least one collision on this frame |
| stat_abt | output | 1 | Aborted after excessive collisions |
| coll_count | output | 4 | Collisions on this frame |

## Verification
The assertions assume that `collision`, `backoff_done` and `end_of_frame` are single-cycle strobes. They also assume that a stalled read address may be withdrawn only by a collision. The directed stimulus drives every strobe for exactly one clock, one cycle after an edge. The only time it raises `collision` while an address is pending is when it means the attempt to fail. It also toggles `rd_ready` during one frame, so stalls occur while the retry machinery is active.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SEND,
    ST_DRAIN,
    ST_BACKOFF
  } tx_state_e;
endpackage

// File: rtl/tx_addr_gen.sv
module tx_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              rewind,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  offset_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      count_q  <= '0;
      offset_q <= '0;
    end else if (load) begin
      page_q   <= page_in;
      count_q  <= count_in;
      offset_q <= '0;
    end else if (rewind) begin
      offset_q <= '0;
    end else if (advance) begin
      offset_q <= offset_q + 1'b1;
    end
  end

  assign addr = {page_q, {LOW_W{1'b0}}} + ADDR_W'(offset_q);
  assign last = (offset_q == count_q);
endmodule

// File: rtl/tx_coll_counter.sv
module tx_coll_counter #(
  parameter int MAX_RETRY = 15,
  localparam int CW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          abort
);
  logic [CW-1:0] count_q;

  assign abort = inc && (count_q == CW'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (clear)  count_q <= '0;
    else if (abort)  count_q <= '0;
    else if (inc)    count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl #(
  parameter int PAGE_W    = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int MAX_RETRY = 15,
  localparam int CW = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              tx_req_set,
  input  logic              rx_busy,
  input  logic              ifg_done,
  input  logic              backoff_done,
  input  logic              collision,
  input  logic              end_of_frame,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fifo_flush,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              stat_ptx,
  output logic              stat_col,
  output logic              stat_abt,
  output logic [CW-1:0]     coll_count
);
  import tx_retry_pkg::*;

  tx_state_e state_q, state_d;
  logic start, coll_hit, abort, last, hs, finish;

  assign start    = tx_req_set && (state_q == ST_IDLE);
  assign coll_hit = collision && ((state_q == ST_SEND) || (state_q == ST_DRAIN));
  assign rd_valid = (state_q == ST_SEND) && !last;
  assign hs       = rd_valid && rd_ready;
  assign finish   = (state_q == ST_DRAIN) && end_of_frame && !coll_hit;
  assign tx_busy  = (state_q != ST_IDLE);

  tx_addr_gen #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .page_in(start_page),
    .count_in(byte_count), .rewind(coll_hit), .advance(hs && !coll_hit),
    .addr(rd_addr), .last(last)
  );

  tx_coll_counter #(.MAX_RETRY(MAX_RETRY)) u_coll (
    .clk(clk), .rst_n(rst_n), .clear(start), .inc(coll_hit),
    .count(coll_count), .abort(abort)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_GAP;
      ST_GAP:     if (!rx_busy && ifg_done) state_d = ST_SEND;
      ST_SEND: begin
        if (coll_hit)  state_d = abort ? ST_IDLE : ST_BACKOFF;
        else if (last) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (coll_hit)          state_d = abort ? ST_IDLE : ST_BACKOFF;
        else if (end_of_frame) state_d = ST_IDLE;
      end
      ST_BACKOFF: if (backoff_done) state_d = ST_GAP;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fifo_flush <= 1'b0;
      tx_done    <= 1'b0;
      stat_ptx   <= 1'b0;
      stat_col   <= 1'b0;
      stat_abt   <= 1'b0;
    end else begin
      state_q    <= state_d;
      fifo_flush <= coll_hit;
      tx_done    <= finish;
      if (start) begin
        stat_ptx <= 1'b0;
        stat_col <= 1'b0;
        stat_abt <= 1'b0;
      end else begin
        if (finish)   stat_ptx <= 1'b1;
        if (coll_hit) stat_col <= 1'b1;
        if (abort)    stat_abt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_retry_ctrl_checker.sv
module tx_retry_ctrl_checker #(
  parameter int ADDR_W = 16,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_req_set,
  input logic              collision,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              fifo_flush,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              stat_ptx,
  input logic              stat_abt,
  input logic [CW-1:0]     coll_count
);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !collision) |=> (rd_valid && $stable(rd_addr)));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(collision));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_count != $past(coll_count)) |->
      ((coll_count == $past(coll_count) + 1'b1) || (coll_count == '0)));

  assert_done_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (stat_ptx && !tx_busy));

  assert_abort_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_abt) |-> ((coll_count == '0) && !tx_busy && !tx_done));

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_req_set));
endmodule

bind tx_retry_ctrl tx_retry_ctrl_checker #(.ADDR_W(ADDR_W), .CW(CW)) u_checker (
  .clk(clk), .rst_n(rst_n), .tx_req_set(tx_req_set), .collision(collision),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .fifo_flush(fifo_flush), .tx_busy(tx_busy), .tx_done(tx_done),
  .stat_ptx(stat_ptx), .stat_abt(stat_abt), .coll_count(coll_count)
);

// File: tb/tx_retry_ctrl_test.sv
`timescale 1ns/1ps
module tx_retry_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  start_page = 0;
  logic [15:0] byte_count = 0;
  logic        tx_req_set = 0, rx_busy = 0, ifg_done = 0;
  logic        backoff_done = 0, collision = 0, end_of_frame = 0;
  logic        rd_valid, rd_ready = 1, fifo_flush, tx_busy, tx_done;
  logic        stat_ptx, stat_col, stat_abt;
  logic [15:0] rd_addr;
  logic [3:0]  coll_count;

  int checks = 0, errors = 0;
  int mon_off = 0, mon_err = 0;
  logic [15:0] exp_base = 0;
  logic stall_mode = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_retry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_page(start_page), .byte_count(byte_count),
    .tx_req_set(tx_req_set), .rx_busy(rx_busy), .ifg_done(ifg_done),
    .backoff_done(backoff_done), .collision(collision), .end_of_frame(end_of_frame),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .fifo_flush(fifo_flush), .tx_busy(tx_busy), .tx_done(tx_done),
    .stat_ptx(stat_ptx), .stat_col(stat_col), .stat_abt(stat_abt),
    .coll_count(coll_count)
  );

  // Accepted addresses are observed half a cycle before the edge that takes them.
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready && !collision) begin
      if (rd_addr !== exp_base + 16'(mon_off)) mon_err++;
      mon_off++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall_mode) rd_ready = ~rd_ready;
    else rd_ready = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_req();      tx_req_set = 1;   tick(1); tx_req_set = 0;   endtask
  task automatic pulse_coll();     collision = 1;    tick(1); collision = 0;    endtask
  task automatic pulse_backoff();  backoff_done = 1; tick(1); backoff_done = 0; endtask
  task automatic pulse_eof();      end_of_frame = 1; tick(1); end_of_frame = 0; endtask

  task automatic wait_off(input int n);
    while (mon_off < n) tick(1);
  endtask

  task automatic wait_valid();
    while (!rd_valid) tick(1);
  endtask

  task automatic test_reset();
    check(!tx_busy && !rd_valid && !fifo_flush && !tx_done, "R1 idle outputs", tx_busy, 0);
    check(!stat_ptx && !stat_col && !stat_abt && coll_count == 0, "R1 status", coll_count, 0);
  endtask

  task automatic test_plain_frame();
    int seen;
    start_page = 8'h12; byte_count = 16'd5; exp_base = 16'h1200;
    mon_off = 0; mon_err = 0; rx_busy = 1; ifg_done = 0;
    tick(1); pulse_req();
    check(tx_busy == 1, "R2 busy after request", tx_busy, 1);
    tick(5);
    check(mon_off == 0 && !rd_valid, "R3 held by receive", mon_off, 0);
    rx_busy = 0; tick(5);
    check(mon_off == 0 && !rd_valid, "R3 held by gap", mon_off, 0);
    ifg_done = 1;
    wait_off(5); tick(3);
    check(!rd_valid && tx_busy, "R5 no reads after last byte", rd_valid, 0);
    seen = mon_off;
    check(seen == 5 && mon_err == 0, "R4 address sequence", mon_err, 0);
    pulse_eof();
    check(tx_done && stat_ptx && !tx_busy, "R5 completion", tx_done, 1);
    tick(1);
    check(!tx_done, "R5 done pulse width", tx_done, 0);
  endtask

  task automatic test_retry();
    start_page = 8'h40; byte_count = 16'd4; exp_base = 16'h4000;
    mon_off = 0; mon_err = 0; rx_busy = 0; ifg_done = 1; stall_mode = 1;
    pulse_req();
    check(!stat_ptx && coll_count == 0, "R2 status cleared", stat_ptx, 0);
    wait_off(2);
    pulse_coll(); mon_off = 0;
    check(fifo_flush && coll_count == 1 && stat_col, "R6 collision effect", coll_count, 1);
    tick(1);
    check(!fifo_flush, "R6 flush pulse width", fifo_flush, 0);
    tick(4);
    check(mon_off == 0 && !rd_valid, "R7 waits for backoff", mon_off, 0);
    pulse_coll(); tick(1);
    check(coll_count == 1 && !fifo_flush, "R9 collision in backoff ignored", coll_count, 1);
    start_page = 8'h77; pulse_req(); start_page = 8'h40;
    ifg_done = 0; pulse_backoff(); tick(4);
    check(mon_off == 0 && !rd_valid, "R7 waits for gap again", mon_off, 0);
    ifg_done = 1;
    wait_off(4); tick(3);
    check(mon_err == 0, "R7 retry from offset 0, R2 busy request ignored", mon_err, 0);
    collision = 1; end_of_frame = 1; tick(1); collision = 0; end_of_frame = 0;
    mon_off = 0;
    check(!tx_done && tx_busy && coll_count == 2 && fifo_flush,
          "R10 late collision wins", coll_count, 2);
    stall_mode = 0;
    pulse_backoff(); wait_off(4); tick(2); pulse_eof();
    check(tx_done && stat_col && coll_count == 2 && mon_err == 0,
          "R5 done after retries", coll_count, 2);
  endtask

  task automatic test_abort();
    start_page = 8'h03; byte_count = 16'd3; exp_base = 16'h0300;
    mon_off = 0; mon_err = 0;
    pulse_req();
    for (int i = 1; i <= 16; i++) begin
      wait_valid();
      pulse_coll(); mon_off = 0;
      if (i < 16) begin
        check(coll_count == i && tx_busy && !stat_abt, "R6 count per collision", coll_count, i);
        pulse_backoff();
      end
    end
    check(stat_abt && coll_count == 0 && !tx_busy, "R8 abort state", coll_count, 0);
    check(!tx_done && stat_col && fifo_flush && !stat_ptx, "R8 abort flags", tx_done, 0);
    tick(3);
    check(!rd_valid && !tx_done, "R8 stays idle", rd_valid, 0);
    pulse_coll(); tick(1);
    check(coll_count == 0 && !fifo_flush, "R9 collision while idle ignored", coll_count, 0);
    pulse_req();
    check(!stat_abt && !stat_col && tx_busy, "R2 restart clears abort", stat_abt, 0);
    wait_off(3); tick(2); pulse_eof();
    check(tx_done && mon_err == 0, "R4 R5 frame after abort", mon_err, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    test_reset();
    test_plain_frame();
    test_retry();
    test_abort();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule